// File: doc/BRIEF.md
# Descriptor Download and Enumeration Sequencer

This block takes a USB descriptor set from an external master over a byte-register command path and prepares the device for attachment. A write request to the load address opens a download. Every byte arrives as two 4-bit transfers. The first two bytes give the total length, and the payload bytes follow. The payload goes into an internal descriptor memory. There is one exception: a length of exactly six means the master supplies only the vendor, product and release identifiers. These are then patched into a built-in default descriptor set.

When the payload is complete, a walker steps through the stored bytes. It uses the bLength and bDescriptorType of each record and notes where the first descriptor of each kind begins. The D+ pull-up enable stays low from the start of a download until the walk succeeds. It then goes high so the host can enumerate. Host enumeration itself is represented by an input strobe. That strobe raises a pending enumeration-done interrupt, which remains set until the master acknowledges it.

Top module: `desc_enum_seq`

## Requirements
- R1: A cycle with `req_valid` high and `req_addr` equal to 0x30 starts a new download. From the next cycle, `pullup_en`, `load_err`, `parse_err` and `loc_found` are all low. Requests to other addresses, and nibbles received while no download is open, change no output.
- R2: Each byte is made of two consecutive `nib_valid` transfers, high nibble first. The first two bytes of a download are the payload length, low byte first.
- R3: For a length from 1 to DEPTH other than 6, payload byte k is stored at offset k. Outside default mode it can be read on `desc_rd_data` at `desc_rd_addr` = k.
- R4: A length of 6 sets `default_mode`. The six bytes are then the vendor, product and release IDs, each sent low byte first. They appear unchanged and in order at offsets 8..13 of a 57-byte default set. That set holds: device at 0 (bLength 18), qualifier at 18 (10), configuration at 28 (9), interface at 37 (9), endpoint at 46 (7) and string at 53 (4).
- R5: A length greater than DEPTH sets `load_err`. No payload is taken, and `pullup_en` stays low until the next download.
- R6: The walker reads bLength at offset p and the type at p+1, then advances p by bLength until p reaches the length. Type codes 1, 6, 2, 4, 5 and 3 (device, qualifier, configuration, interface, endpoint, string) map to `loc_found` bits 0 to 5. Each bit's offset is in `loc_offs[i*9 +: 9]`, and only the first descriptor of each type is recorded.
- R7: A bLength of zero met before the end of the payload stops the walk and sets `parse_err`, with `pullup_en` left low.
- R8: After a successful walk, `pullup_en` goes high and stays high until the next download starts.
- R9: `enum_done` sampled while `pullup_en` is high sets `enumok_irq` on the next cycle. At any other time it is ignored.
- R10: `enumok_irq` stays set until an `irq_ack` cycle, and clears on the cycle after the ack. When a set and an ack happen in the same cycle, the set wins.
- R11: A length of 0 gives a walk that finds nothing. `loc_found` is 0 and `pullup_en` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register write request strobe |
| req_addr | input | 6 | Register address of the request |
| nib_valid | input | 1 | Nibble transfer strobe |
| nib_data | input | 4 | Nibble value |
| enum_done | input | 1 | Host enumeration finished (strobe) |
| irq_ack | input | 1 | Interrupt status read, clears pending interrupt |
| desc_rd_addr | input | 9 | Descriptor read offset |
| desc_rd_data | output | 8 | Descriptor byte at that offset (default set in default mode) |
| pullup_en | output | 1 | D+ pull-up enable |
| enumok_irq | output | 1 | Enumeration-done interrupt pending |
| default_mode | output | 1 | Built-in descriptor set with patched IDs in use |
| load_err | output | 1 | Length exceeded memory size |
| parse_err | output | 1 | Zero bLength met during walk |
| loc_found | output | 6 | Descriptor kinds located |
| loc_offs | output | 54 | Start offset of each located kind, 9 bits each |

## Verification
The walker runs over six descriptor chains. Each chain is built arithmetically with a rotated type order and different record lengths, and the odd trials add a repeated type. This separates first-occurrence recording from last-occurrence recording and shows the step size is taken from bLength. Further downloads cover the six-byte ID form, a payload that fills the memory exactly, a payload one byte too long, an empty payload and a chain broken by a zero bLength. Together these cover the default/custom switch, the size boundary and both error paths. The interrupt is tested with strobes arriving before and after the pull-up rises, and with acknowledge and set landing in the same cycle.

// File: rtl/desc_enum_pkg.sv
package desc_enum_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_LEN, ST_DATA, ST_PARSE, ST_LIVE, ST_HALT
   } seq_state_t;

   localparam int NKIND   = 6;
   localparam int DEF_LEN = 57;
   localparam logic [2:0] SLOT_NONE = 3'd7;

   // slot order: device, qualifier, configuration, interface, endpoint, string
   function automatic logic [2:0] kind_slot(input logic [7:0] dtype);
      case (dtype)
         8'd1:    return 3'd0;
         8'd6:    return 3'd1;
         8'd2:    return 3'd2;
         8'd4:    return 3'd3;
         8'd5:    return 3'd4;
         8'd3:    return 3'd5;
         default: return SLOT_NONE;
      endcase
   endfunction
endpackage

// File: rtl/nib_pack.sv
module nib_pack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [3:0] nib,
   output logic       byte_v,
   output logic [7:0] byte_d
);
   logic       phase;
   logic [3:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         phase <= 1'b0;
         hi_q  <= 4'h0;
      end else if (en) begin
         phase <= ~phase;
         if (!phase) hi_q <= nib;
      end
   end

   assign byte_v = en && phase && !clr;
   assign byte_d = {hi_q, nib};
endmodule

// File: rtl/desc_store.sv
module desc_store #(
   parameter int DEPTH = 512,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          id_we,
   input  logic [2:0]    id_idx,
   input  logic          def_mode,
   input  logic [AW-1:0] pa_addr,
   output logic [7:0]    pa_data,
   input  logic [AW-1:0] pb_addr,
   output logic [7:0]    pb_data,
   input  logic [AW-1:0] ext_addr,
   output logic [7:0]    ext_data
);
   logic [7:0]  mem [DEPTH];
   logic [47:0] ids;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (id_we) ids[int'(id_idx)*8 +: 8] <= wr_data;
   end

   function automatic logic [7:0] def_byte(input logic [AW-1:0] a, input logic [47:0] idv);
      case (int'(a))
         0:  return 8'd18;
         1:  return 8'd1;
         3:  return 8'h02;
         7:  return 8'd64;
         8:  return idv[7:0];
         9:  return idv[15:8];
         10: return idv[23:16];
         11: return idv[31:24];
         12: return idv[39:32];
         13: return idv[47:40];
         17: return 8'd1;
         18: return 8'd10;
         19: return 8'd6;
         28: return 8'd9;
         29: return 8'd2;
         30: return 8'd25;
         37: return 8'd9;
         38: return 8'd4;
         46: return 8'd7;
         47: return 8'd5;
         53: return 8'd4;
         54: return 8'd3;
         default: return 8'h00;
      endcase
   endfunction

   assign pa_data  = def_mode ? def_byte(pa_addr, ids)  : mem[pa_addr];
   assign pb_data  = def_mode ? def_byte(pb_addr, ids)  : mem[pb_addr];
   assign ext_data = def_mode ? def_byte(ext_addr, ids) : mem[ext_addr];
endmodule

// File: rtl/desc_walker.sv
module desc_walker
   import desc_enum_pkg::*;
#(
   parameter int AW = 9,
   parameter int LW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                go,
   input  logic [LW-1:0]       total_len,
   output logic [AW-1:0]       rd_addr0,
   output logic [AW-1:0]       rd_addr1,
   input  logic [7:0]          blen,
   input  logic [7:0]          btype,
   output logic                done,
   output logic                err,
   output logic [NKIND-1:0]    found,
   output logic [NKIND*AW-1:0] offs
);
   logic [LW:0] pos;
   logic        busy;
   logic [2:0]  slot;

   assign slot     = kind_slot(btype);
   assign rd_addr0 = pos[AW-1:0];
   assign rd_addr1 = pos[AW-1:0] + AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         pos   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
         err   <= 1'b0;
         found <= '0;
         offs  <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            pos   <= '0;
            busy  <= 1'b1;
            err   <= 1'b0;
            found <= '0;
         end else if (busy) begin
            if (pos >= {1'b0, total_len}) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else if (blen == 8'd0) begin
               busy <= 1'b0;
               done <= 1'b1;
               err  <= 1'b1;
            end else begin
               if (slot != SLOT_NONE && !found[slot]) begin
                  found[slot] <= 1'b1;
                  offs[int'(slot)*AW +: AW] <= pos[AW-1:0];
               end
               pos <= pos + (LW+1)'(blen);
            end
         end
      end
   end
endmodule

// File: rtl/desc_enum_seq.sv
module desc_enum_seq
   import desc_enum_pkg::*;
#(
   parameter int          DEPTH     = 512,
   parameter int          AW        = $clog2(DEPTH),
   parameter logic [5:0]  LOAD_ADDR = 6'h30
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [5:0]          req_addr,
   input  logic                nib_valid,
   input  logic [3:0]          nib_data,
   input  logic                enum_done,
   input  logic                irq_ack,
   input  logic [AW-1:0]       desc_rd_addr,
   output logic [7:0]          desc_rd_data,
   output logic                pullup_en,
   output logic                enumok_irq,
   output logic                default_mode,
   output logic                load_err,
   output logic                parse_err,
   output logic [NKIND-1:0]    loc_found,
   output logic [NKIND*AW-1:0] loc_offs
);
   localparam int          LW      = 16;
   localparam logic [LW:0] DEPTH_W = (LW+1)'(DEPTH);
   localparam logic [LW-1:0] DEF_W = LW'(DEF_LEN);

   generate
      if (DEPTH < DEF_LEN || DEPTH > 65535) begin : g_bad_depth
         $error("desc_enum_seq: DEPTH must lie in [57, 65535]");
      end
   endgenerate

   seq_state_t    state;
   logic [LW-1:0] len_q, cnt_q;
   logic [7:0]    len_lo;
   logic          go_q;
   logic          start, byte_v, in_load;
   logic [7:0]    byte_d;
   logic [LW-1:0] len_now;
   logic          w_done, w_err;
   logic [AW-1:0] ra0, ra1;
   logic [7:0]    rd0, rd1;

   assign start   = req_valid && (req_addr == LOAD_ADDR);
   assign in_load = (state == ST_LEN) || (state == ST_DATA);
   assign len_now = {byte_d, len_lo};

   nib_pack u_pack (
      .clk(clk), .rst_n(rst_n), .clr(start),
      .en(in_load && nib_valid), .nib(nib_data),
      .byte_v(byte_v), .byte_d(byte_d)
   );

   desc_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk(clk),
      .wr_en(state == ST_DATA && byte_v && !default_mode),
      .wr_addr(cnt_q[AW-1:0]), .wr_data(byte_d),
      .id_we(state == ST_DATA && byte_v && default_mode),
      .id_idx(cnt_q[2:0]), .def_mode(default_mode),
      .pa_addr(ra0), .pa_data(rd0),
      .pb_addr(ra1), .pb_data(rd1),
      .ext_addr(desc_rd_addr), .ext_data(desc_rd_data)
   );

   desc_walker #(.AW(AW), .LW(LW)) u_walk (
      .clk(clk), .rst_n(rst_n), .clr(start), .go(go_q),
      .total_len(default_mode ? DEF_W : len_q),
      .rd_addr0(ra0), .rd_addr1(ra1), .blen(rd0), .btype(rd1),
      .done(w_done), .err(w_err), .found(loc_found), .offs(loc_offs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         len_q        <= '0;
         len_lo       <= '0;
         cnt_q        <= '0;
         go_q         <= 1'b0;
         default_mode <= 1'b0;
         load_err     <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (start) begin
            state        <= ST_LEN;
            cnt_q        <= '0;
            default_mode <= 1'b0;
            load_err     <= 1'b0;
         end else begin
            case (state)
               ST_LEN: if (byte_v) begin
                  if (cnt_q == '0) begin
                     len_lo <= byte_d;
                     cnt_q  <= LW'(1);
                  end else begin
                     cnt_q <= '0;
                     len_q <= len_now;
                     if ({1'b0, len_now} > DEPTH_W) begin
                        load_err <= 1'b1;
                        state    <= ST_HALT;
                     end else if (len_now == '0) begin
                        state <= ST_PARSE;
                        go_q  <= 1'b1;
                     end else begin
                        default_mode <= (len_now == LW'(6));
                        state        <= ST_DATA;
                     end
                  end
               end
               ST_DATA: if (byte_v) begin
                  cnt_q <= cnt_q + LW'(1);
                  if (cnt_q == len_q - LW'(1)) begin
                     state <= ST_PARSE;
                     go_q  <= 1'b1;
                  end
               end
               ST_PARSE: if (w_done) state <= w_err ? ST_HALT : ST_LIVE;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                  enumok_irq <= 1'b0;
      else if (enum_done && state == ST_LIVE)      enumok_irq <= 1'b1;
      else if (irq_ack)                            enumok_irq <= 1'b0;
   end

   assign pullup_en = (state == ST_LIVE);
   assign parse_err = w_err;
endmodule

// File: rtl/desc_enum_seq_chk.sv
module desc_enum_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [5:0] req_addr,
   input logic       enum_done,
   input logic       irq_ack,
   input logic       pullup_en,
   input logic       enumok_irq,
   input logic       load_err,
   input logic       parse_err
);
   assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr == 6'h30) |=> (!pullup_en && !load_err && !parse_err));

   assert_oversize_no_pullup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> !pullup_en);

   assert_zero_blen_no_pullup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      parse_err |-> !pullup_en);

   assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enum_done && pullup_en) |=> enumok_irq);

   assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enumok_irq) |-> $past(enum_done && pullup_en));

   assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (enumok_irq && !irq_ack) |=> enumok_irq);

   assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !(enum_done && pullup_en)) |=> !enumok_irq);
endmodule

bind desc_enum_seq desc_enum_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .enum_done(enum_done), .irq_ack(irq_ack), .pullup_en(pullup_en),
   .enumok_irq(enumok_irq), .load_err(load_err), .parse_err(parse_err)
);

// File: tb/desc_enum_seq_bench.sv
module desc_enum_seq_bench;
   localparam int AW = 9;
   localparam int CLK_NS = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_addr = '0;
   logic        nib_valid = 1'b0;
   logic [3:0]  nib_data = '0;
   logic        enum_done = 1'b0;
   logic        irq_ack = 1'b0;
   logic [8:0]  desc_rd_addr = '0;
   logic [7:0]  desc_rd_data;
   logic        pullup_en, enumok_irq, default_mode, load_err, parse_err;
   logic [5:0]  loc_found;
   logic [53:0] loc_offs;

   int tests = 0;
   int fails = 0;
   logic [7:0] img [512];
   int exp_off [6];
   logic [5:0] exp_found;

   always #(CLK_NS/2) clk = ~clk;

   desc_enum_seq u_desc_enum_seq (.*);

   task automatic chk(input string tag, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_req(input logic [5:0] a);
      @(negedge clk); req_valid = 1'b1; req_addr = a;
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk); nib_valid = 1'b1; nib_data = b[7:4];
      @(negedge clk); nib_data = b[3:0];
      @(negedge clk); nib_valid = 1'b0;
   endtask

   task automatic settle();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (pullup_en || parse_err || load_err) break;
      end
   endtask

   task automatic load(input int n);
      send_req(6'h30);
      send_byte(n[7:0]);
      send_byte(n[15:8]);
      if (n <= 512) for (int i = 0; i < n; i++) send_byte(img[i]);
      settle();
   endtask

   function automatic logic [7:0] code_of(input int s);
      case (s)
         0: return 8'd1; 1: return 8'd6; 2: return 8'd2;
         3: return 8'd4; 4: return 8'd5; default: return 8'd3;
      endcase
   endfunction

   task automatic rd(input int a, output logic [7:0] v);
      @(negedge clk); desc_rd_addr = 9'(a); #1 v = desc_rd_data;
   endtask

   task automatic check_locs(input string tag);
      chk({tag, " found"}, loc_found, exp_found);
      for (int s = 0; s < 6; s++)
         if (exp_found[s]) chk({tag, " offset"}, loc_offs[s*AW +: AW], exp_off[s]);
   endtask

   initial begin
      #(CLK_NS * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int total;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset R8 pullup", pullup_en, 0);
      chk("reset R9 irq", enumok_irq, 0);
      chk("reset R5 load_err", load_err, 0);
      chk("reset R6 found", loc_found, 0);

      // R2 R4: six-byte ID download into the default set
      img[0] = 8'hB4; img[1] = 8'h04; img[2] = 8'h02;
      img[3] = 8'h10; img[4] = 8'h01; img[5] = 8'h00;
      load(6);
      chk("R4 default_mode", default_mode, 1);
      chk("R8 pullup after default", pullup_en, 1);
      for (int k = 0; k < 6; k++) begin
         rd(8 + k, v);
         chk("R4 patched id byte", v, img[k]);
      end
      rd(0, v); chk("R4 device bLength", v, 18);
      exp_found = 6'h3F;
      exp_off[0] = 0; exp_off[1] = 18; exp_off[2] = 28;
      exp_off[3] = 37; exp_off[4] = 46; exp_off[5] = 53;
      check_locs("R4 R6 default");

      // R9 R10 interrupt
      @(negedge clk); enum_done = 1'b1;
      @(negedge clk); enum_done = 1'b0;
      chk("R9 irq set", enumok_irq, 1);
      repeat (4) @(negedge clk);
      chk("R10 irq held", enumok_irq, 1);
      enum_done = 1'b1; irq_ack = 1'b1;
      @(negedge clk); enum_done = 1'b0; irq_ack = 1'b0;
      chk("R10 set wins over ack", enumok_irq, 1);
      irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      chk("R10 ack clears", enumok_irq, 0);

      // R1 other address ignored
      send_req(6'h31);
      send_byte(8'h77);
      chk("R1 other addr pullup", pullup_en, 1);
      rd(8, v); chk("R1 other addr data", v, 8'hB4);
      chk("R1 other addr found", loc_found, 6'h3F);

      // R1 restart drops pullup
      @(negedge clk); req_valid = 1'b1; req_addr = 6'h30;
      @(negedge clk); req_valid = 1'b0;
      chk("R1 restart pullup", pullup_en, 0);
      chk("R1 restart found", loc_found, 0);

      // R3 R6 R8 sweep of descriptor chains
      for (int t = 0; t < 6; t++) begin
         int off;
         int ndesc;
         off = 0;
         exp_found = '0;
         ndesc = (t % 2 == 1) ? 7 : 6;
         for (int i = 0; i < ndesc; i++) begin
            int s, L;
            s = (i + t) % 6;
            L = 2 + ((i * 3 + t) % 7);
            img[off] = 8'(L);
            img[off + 1] = code_of(s);
            for (int j = 2; j < L; j++) img[off + j] = 8'((off + j) * 13 + t);
            if (!exp_found[s]) begin
               exp_found[s] = 1'b1;
               exp_off[s] = off;
            end
            off += L;
         end
         total = off;
         load(total);
         chk("R8 pullup sweep", pullup_en, 1);
         chk("R3 custom mode", default_mode, 0);
         check_locs("R6 sweep");
         for (int a = 0; a < total; a++) begin
            rd(a, v);
            chk("R3 stored byte", v, img[a]);
         end
      end

      // R3 R6 exact-fit 512 bytes
      for (int a = 0; a < 512; a++) img[a] = 8'(a ^ 8'h3C);
      img[0] = 8'd255; img[1] = 8'd1;
      img[255] = 8'd255; img[256] = 8'd2;
      img[510] = 8'd2; img[511] = 8'd3;
      load(512);
      chk("R5 512 no load_err", load_err, 0);
      chk("R8 512 pullup", pullup_en, 1);
      exp_found = 6'b100101;
      exp_off[0] = 0; exp_off[2] = 255; exp_off[5] = 510;
      check_locs("R6 512");
      rd(511, v); chk("R3 last byte", v, 8'd3);

      // R7 zero bLength
      img[0] = 8'd4; img[1] = 8'd1; img[2] = 8'h11; img[3] = 8'h22;
      img[4] = 8'd0; img[5] = 8'd2; img[6] = 8'h33; img[7] = 8'h44;
      img[8] = 8'h55; img[9] = 8'h66;
      load(10);
      repeat (3) @(negedge clk);
      chk("R7 parse_err", parse_err, 1);
      chk("R7 pullup low", pullup_en, 0);
      chk("R7 found dev only", loc_found, 6'b000001);

      // R9 enum_done ignored while pullup low
      @(negedge clk); enum_done = 1'b1;
      @(negedge clk); enum_done = 1'b0;
      chk("R9 ignored when halted", enumok_irq, 0);

      // R5 oversize
      load(513);
      chk("R5 load_err", load_err, 1);
      send_byte(8'h12); send_byte(8'h34);
      repeat (5) @(negedge clk);
      chk("R5 pullup low", pullup_en, 0);
      chk("R5 found none", loc_found, 0);

      // R11 empty payload
      load(0);
      repeat (2) @(negedge clk);
      chk("R11 pullup", pullup_en, 1);
      chk("R11 found", loc_found, 0);
      chk("R11 no errors", {load_err, parse_err}, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule